// File: doc/BRIEF.md
# RV32I Single-Cycle Control Decoder

This block is the control decoder of a core that retires one RV32I instruction per clock. It sees the 32-bit instruction word and the two flags from the branch comparator (operands equal, operand A less than operand B). It drives every select and enable that the datapath muxes, register file, ALU and data memory need in that cycle. It has no state: every output follows the inputs within the same cycle.

The decoder handles five instruction classes:
- register-register arithmetic
- register-immediate arithmetic
- word loads
- word stores
- the six conditional branches

For a branch, the ALU forms the target from the PC and the immediate. The next-PC select then picks the ALU result only when the comparator flags satisfy the branch condition. Any other encoding is treated as unsupported and leaves architectural state untouched. That includes other opcodes, narrow loads and stores, illegal funct7 patterns and undefined branch funct3 values.

Data does not stream through this block. All of its pins are plain control levels with no valid/ready handshake, so there is no back-pressure to honour.

Top module: `rvd_ctrl_dec`

## Requirements
- R1: For opcode 0110011 with funct3 000 and instr[31:25] equal to 0000000 or 0100000: reg_we_o=1, a_sel_o=0 (rs1), b_sel_o=0 (rs2), wb_sel_o=1 (ALU), mem_wr_o=0, pc_sel_o=0. alu_sel_o is 0 (add) when instr[30]=0 and 1 (subtract) when instr[30]=1.
- R2: For the other register-register funct3 values, alu_sel_o is 2 for funct3 001 (sll), 3 for 010 (slt), 4 for 011 (sltu), 5 for 100 (xor), 6 for 101 (srl), 8 for 110 (or) and 9 for 111 (and). With instr[31:25]=0100000 and funct3 101 it is 7 (sra). The other controls are as in R1.
- R3: A register-register instruction with any other instr[31:25] pattern is unsupported: reg_we_o=0, mem_wr_o=0, pc_sel_o=0.
- R4: For opcode 0010011: imm_sel_o=0 (I-format), a_sel_o=0, b_sel_o=1 (immediate), wb_sel_o=1, reg_we_o=1, mem_wr_o=0, pc_sel_o=0. alu_sel_o follows the funct3 map of R2, and funct3 000 gives 0 whatever instr[30] is.
- R5: For opcode 0010011, a shift by immediate is legal only with instr[31:25]=0000000 (funct3 001 or 101) or 0100000 (funct3 101, giving alu_sel_o=7). Any other pattern gives reg_we_o=0. For the remaining funct3 values, instr[31:25] has no effect.
- R6: Opcode 0000011 with funct3 010 (word load) gives imm_sel_o=0, a_sel_o=0, b_sel_o=1, alu_sel_o=0, mem_wr_o=0, wb_sel_o=0 (memory), reg_we_o=1 and pc_sel_o=0.
- R7: Opcode 0100011 with funct3 010 (word store) gives imm_sel_o=1 (S-format), a_sel_o=0, b_sel_o=1, alu_sel_o=0, mem_wr_o=1, reg_we_o=0 and pc_sel_o=0.
- R8: Opcode 1100011 gives imm_sel_o=2 (B-format), a_sel_o=1 (PC), b_sel_o=1, alu_sel_o=0, reg_we_o=0 and mem_wr_o=0. br_un_o=1 exactly for funct3 110 and 111.
- R9: A branch sets pc_sel_o=1 (ALU result) exactly when it is taken:
  - funct3 000: br_eq_i
  - funct3 001: !br_eq_i
  - funct3 100 or 110: br_lt_i
  - funct3 101 or 111: !br_lt_i
  - funct3 010 or 011: never taken
- R10: Any other opcode, and loads or stores whose funct3 is not 010, give reg_we_o=0, mem_wr_o=0 and pc_sel_o=0.
- R11: The block is combinational. Outputs settle to the decode of the present inputs within the same cycle, with no clock or register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word being executed |
| br_eq_i | input | 1 | Comparator: rs1 equals rs2 |
| br_lt_i | input | 1 | Comparator: rs1 less than rs2 (signedness per br_un_o) |
| imm_sel_o | output | 3 | Immediate format: 0 I, 1 S, 2 B |
| reg_we_o | output | 1 | Register file write enable |
| a_sel_o | output | 1 | ALU operand A: 0 rs1, 1 PC |
| b_sel_o | output | 1 | ALU operand B: 0 rs2, 1 immediate |
| alu_sel_o | output | 4 | ALU operation code |
| mem_wr_o | output | 1 | Data memory: 1 write, 0 read |
| wb_sel_o | output | 1 | Writeback source: 0 memory, 1 ALU |
| br_un_o | output | 1 | Comparator uses unsigned compare |
| pc_sel_o | output | 1 | Next PC: 0 PC+4, 1 ALU result |

## Verification
The assertions check, on every input change, the cross-output rules that hold for any instruction word:
- a memory write never comes with a register write;
- a PC redirect only comes from the branch opcode;
- PC as operand A always pairs with the immediate and an add;
- unsupported opcodes leave every state-changing enable low.

Whether each field holds the right value for a given class needs the bench's scenarios. These include:
- each ALU code;
- sub versus add, and srai versus srli;
- instr[30] being ignored for addi;
- the signed and unsigned branch conditions under every flag combination;
- the rejection of illegal funct7 patterns and narrow memory accesses.

// File: rtl/rvd_ctrl_pkg.sv
package rvd_ctrl_pkg;
  localparam int ILEN    = 32;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int F7_W    = 7;
  localparam int ALU_W   = 4;
  localparam int IMMS_W  = 3;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;

  localparam logic [F3_W-1:0] F3_WORD = 3'b010;
  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  typedef enum logic [2:0] {
    CL_NONE, CL_REG, CL_IMM, CL_LOAD, CL_STORE, CL_BRANCH
  } iclass_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD  = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
    ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
    ALU_OR   = 4'd8, ALU_AND = 4'd9
  } alu_op_e;

  typedef enum logic [IMMS_W-1:0] {
    IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2
  } imm_fmt_e;
endpackage

// File: rtl/rvd_opclass.sv
module rvd_opclass
  import rvd_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [F3_W-1:0]  funct3_i,
  output iclass_e          class_o
);
  always_comb begin
    unique case (opcode_i)
      OPC_REG:    class_o = CL_REG;
      OPC_IMM:    class_o = CL_IMM;
      OPC_LOAD:   class_o = (funct3_i == F3_WORD) ? CL_LOAD  : CL_NONE;
      OPC_STORE:  class_o = (funct3_i == F3_WORD) ? CL_STORE : CL_NONE;
      OPC_BRANCH: class_o = CL_BRANCH;
      default:    class_o = CL_NONE;
    endcase
  end
endmodule

// File: rtl/rvd_alu_dec.sv
module rvd_alu_dec
  import rvd_ctrl_pkg::*;
(
  input  iclass_e         class_i,
  input  logic [F3_W-1:0] funct3_i,
  input  logic [F7_W-1:0] funct7_i,
  output alu_op_e         alu_o,
  output logic            legal_o
);
  logic f7_base, f7_alt, alt_bit;
  alu_op_e base_op;

  assign f7_base = (funct7_i == F7_BASE);
  assign f7_alt  = (funct7_i == F7_ALT);
  assign alt_bit = f7_alt;

  // funct3 to operation, without any alternate-form selection
  always_comb begin
    unique case (funct3_i)
      3'b000:  base_op = ALU_ADD;
      3'b001:  base_op = ALU_SLL;
      3'b010:  base_op = ALU_SLT;
      3'b011:  base_op = ALU_SLTU;
      3'b100:  base_op = ALU_XOR;
      3'b101:  base_op = ALU_SRL;
      3'b110:  base_op = ALU_OR;
      default: base_op = ALU_AND;
    endcase
  end

  always_comb begin
    alu_o   = ALU_ADD;
    legal_o = 1'b1;
    unique case (class_i)
      CL_REG: begin
        alu_o = base_op;
        if (alt_bit && funct3_i == 3'b000) alu_o = ALU_SUB;
        if (alt_bit && funct3_i == 3'b101) alu_o = ALU_SRA;
        legal_o = f7_base || (f7_alt && (funct3_i == 3'b000 || funct3_i == 3'b101));
      end
      CL_IMM: begin
        alu_o = base_op;
        if (funct3_i == 3'b101) begin
          if (alt_bit) alu_o = ALU_SRA;
          legal_o = f7_base || f7_alt;
        end else if (funct3_i == 3'b001) begin
          legal_o = f7_base;
        end
      end
      CL_LOAD, CL_STORE, CL_BRANCH: alu_o = ALU_ADD;
      default: begin
        alu_o   = ALU_ADD;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rvd_branch_res.sv
module rvd_branch_res
  import rvd_ctrl_pkg::*;
(
  input  iclass_e         class_i,
  input  logic [F3_W-1:0] funct3_i,
  input  logic            eq_i,
  input  logic            lt_i,
  output logic            unsigned_o,
  output logic            taken_o
);
  logic is_br, cond;

  assign is_br = (class_i == CL_BRANCH);

  always_comb begin
    unique case (funct3_i)
      3'b000:         cond = eq_i;
      3'b001:         cond = !eq_i;
      3'b100, 3'b110: cond = lt_i;
      3'b101, 3'b111: cond = !lt_i;
      default:        cond = 1'b0;
    endcase
  end

  assign unsigned_o = is_br && funct3_i[2] && funct3_i[1];
  assign taken_o    = is_br && cond;
endmodule

// File: rtl/rvd_ctrl_dec.sv
module rvd_ctrl_dec
  import rvd_ctrl_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        br_eq_i,
  input  logic        br_lt_i,
  output logic [2:0]  imm_sel_o,
  output logic        reg_we_o,
  output logic        a_sel_o,
  output logic        b_sel_o,
  output logic [3:0]  alu_sel_o,
  output logic        mem_wr_o,
  output logic        wb_sel_o,
  output logic        br_un_o,
  output logic        pc_sel_o
);
  logic [OPC_W-1:0] opcode;
  logic [F3_W-1:0]  funct3;
  logic [F7_W-1:0]  funct7;
  iclass_e          cls;
  alu_op_e          alu_op;
  logic             legal;
  logic             taken;

  assign opcode = instr_i[OPC_W-1:0];
  assign funct3 = instr_i[14:12];
  assign funct7 = instr_i[ILEN-1:ILEN-F7_W];

  rvd_opclass u_cls (
    .opcode_i(opcode), .funct3_i(funct3), .class_o(cls)
  );

  rvd_alu_dec u_alu (
    .class_i(cls), .funct3_i(funct3), .funct7_i(funct7),
    .alu_o(alu_op), .legal_o(legal)
  );

  rvd_branch_res u_br (
    .class_i(cls), .funct3_i(funct3), .eq_i(br_eq_i), .lt_i(br_lt_i),
    .unsigned_o(br_un_o), .taken_o(taken)
  );

  always_comb begin
    unique case (cls)
      CL_STORE:  imm_sel_o = IMM_S;
      CL_BRANCH: imm_sel_o = IMM_B;
      default:   imm_sel_o = IMM_I;
    endcase
  end

  assign reg_we_o  = legal && (cls == CL_REG || cls == CL_IMM || cls == CL_LOAD);
  assign a_sel_o   = (cls == CL_BRANCH);
  assign b_sel_o   = (cls == CL_IMM) || (cls == CL_LOAD) || (cls == CL_STORE) || (cls == CL_BRANCH);
  assign alu_sel_o = alu_op;
  assign mem_wr_o  = (cls == CL_STORE);
  assign wb_sel_o  = (cls != CL_LOAD);
  assign pc_sel_o  = taken;
endmodule

// File: rtl/rvd_ctrl_chk.sv
module rvd_ctrl_chk (
  input logic [31:0] instr,
  input logic [2:0]  imm_sel,
  input logic        reg_we,
  input logic        a_sel,
  input logic        b_sel,
  input logic [3:0]  alu_sel,
  input logic        mem_wr,
  input logic        pc_sel
);
  logic known_opc;
  assign known_opc = (instr[6:0] == 7'b0110011) || (instr[6:0] == 7'b0010011) ||
                     (instr[6:0] == 7'b0000011) || (instr[6:0] == 7'b0100011) ||
                     (instr[6:0] == 7'b1100011);

  always_comb begin
    // R7
    store_no_wb_chk: assert (!(mem_wr && reg_we))
      else $error("memory write together with register write");
    // R9
    redirect_src_chk: assert (!pc_sel || instr[6:0] == 7'b1100011)
      else $error("PC redirect from non-branch opcode");
    // R8
    pc_operand_chk: assert (!a_sel || (b_sel && alu_sel == 4'd0 && imm_sel == 3'd2))
      else $error("PC operand without immediate add");
    // R10
    unsupported_quiet_chk: assert (known_opc || (!reg_we && !mem_wr && !pc_sel))
      else $error("unsupported opcode changed state");
    // R7
    store_fmt_chk: assert (!mem_wr || (imm_sel == 3'd1 && b_sel && alu_sel == 4'd0))
      else $error("store without S immediate add");
  end
endmodule

bind rvd_ctrl_dec rvd_ctrl_chk chk_i (
  .instr(instr_i), .imm_sel(imm_sel_o), .reg_we(reg_we_o), .a_sel(a_sel_o),
  .b_sel(b_sel_o), .alu_sel(alu_sel_o), .mem_wr(mem_wr_o), .pc_sel(pc_sel_o)
);

// File: tb/rvd_ctrl_dec_tb_top.sv
module rvd_ctrl_dec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr;
  logic eq, lt;
  logic [2:0] imm_sel;
  logic reg_we, a_sel, b_sel, mem_wr, wb_sel, br_un, pc_sel;
  logic [3:0] alu_sel;

  rvd_ctrl_dec dut_i (
    .instr_i(instr), .br_eq_i(eq), .br_lt_i(lt), .imm_sel_o(imm_sel),
    .reg_we_o(reg_we), .a_sel_o(a_sel), .b_sel_o(b_sel), .alu_sel_o(alu_sel),
    .mem_wr_o(mem_wr), .wb_sel_o(wb_sel), .br_un_o(br_un), .pc_sel_o(pc_sel)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic done = 1'b0;

  // expected values and care flags, filled by the model
  logic [2:0] e_imm; logic [3:0] e_alu;
  logic e_we, e_a, e_b, e_mw, e_wb, e_un, e_pc;
  logic c_imm, c_alu, c_a, c_b, c_wb, c_un;
  string tag;

  task automatic model(input logic [31:0] w, input logic feq, input logic flt);
    int f3, f7, op;
    op = int'(w[6:0]); f3 = int'(w[14:12]); f7 = int'(w[31:25]);
    e_imm = 0; e_alu = 0; e_we = 0; e_a = 0; e_b = 0; e_mw = 0; e_wb = 0; e_un = 0; e_pc = 0;
    c_imm = 0; c_alu = 0; c_a = 0; c_b = 0; c_wb = 0; c_un = 0;
    tag = "R10";
    if (op == 'h33) begin
      if (f7 == 0 || (f7 == 'h20 && (f3 == 0 || f3 == 5))) begin
        tag = (f3 == 0) ? "R1" : "R2";
        e_we = 1; c_a = 1; c_b = 1; c_wb = 1; e_wb = 1; c_alu = 1;
        e_alu = alu_code(f3, f7 == 'h20);
      end else tag = "R3";
    end else if (op == 'h13) begin
      if ((f3 == 1 && f7 != 0) || (f3 == 5 && f7 != 0 && f7 != 'h20)) tag = "R5";
      else begin
        tag = (f3 == 1 || f3 == 5) ? "R5" : "R4";
        e_we = 1; c_imm = 1; c_a = 1; c_b = 1; e_b = 1; c_wb = 1; e_wb = 1; c_alu = 1;
        e_alu = alu_code(f3, f3 == 5 && f7 == 'h20);
      end
    end else if (op == 'h03 && f3 == 2) begin
      tag = "R6"; e_we = 1; c_imm = 1; c_a = 1; c_b = 1; e_b = 1; c_alu = 1; c_wb = 1; e_wb = 0;
    end else if (op == 'h23 && f3 == 2) begin
      tag = "R7"; e_mw = 1; c_imm = 1; e_imm = 1; c_a = 1; c_b = 1; e_b = 1; c_alu = 1;
    end else if (op == 'h63) begin
      tag = "R9"; c_imm = 1; e_imm = 2; c_a = 1; e_a = 1; c_b = 1; e_b = 1; c_alu = 1; c_un = 1;
      e_un = (f3 >= 6);
      if (f3 == 0) e_pc = feq;
      else if (f3 == 1) e_pc = !feq;
      else if (f3 == 4 || f3 == 6) e_pc = flt;
      else if (f3 == 5 || f3 == 7) e_pc = !flt;
      else e_pc = 0;
    end
  endtask

  function automatic logic [3:0] alu_code(input int f3, input logic alt);
    if (f3 == 0) return alt ? 4'd1 : 4'd0;
    if (f3 == 5) return alt ? 4'd7 : 4'd6;
    if (f3 == 6) return 4'd8;
    if (f3 == 7) return 4'd9;
    return 4'(f3 + 1);
  endfunction

  task automatic chk(input string what, input logic [3:0] act, input logic [3:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s instr=%h actual=%0d expected=%0d", tag, what, instr, act, expv);
    end
  endtask

  // R11: outputs compared every clock against the decode of the inputs driven that cycle
  always @(negedge clk) begin
    if (!done) begin
      model(instr, eq, lt);
      if (!rst_n) tag = "R10 reset";
      chk("reg_we", {3'b0, reg_we}, {3'b0, e_we});
      chk("mem_wr", {3'b0, mem_wr}, {3'b0, e_mw});
      chk("pc_sel", {3'b0, pc_sel}, {3'b0, e_pc});
      if (c_imm) chk("imm_sel", {1'b0, imm_sel}, {1'b0, e_imm});
      if (c_alu) chk("alu_sel", alu_sel, e_alu);
      if (c_a)   chk("a_sel", {3'b0, a_sel}, {3'b0, e_a});
      if (c_b)   chk("b_sel", {3'b0, b_sel}, {3'b0, e_b});
      if (c_wb)  chk("wb_sel", {3'b0, wb_sel}, {3'b0, e_wb});
      if (c_un)  chk("br_un", {3'b0, br_un}, {3'b0, e_un});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic drive(input logic [31:0] w, input logic feq, input logic flt);
    @(posedge clk); #1;
    instr = w; eq = feq; lt = flt;
  endtask

  function automatic logic [31:0] enc(input int f7, input int f3, input int op);
    return {7'(f7), 5'd3, 5'd2, 3'(f3), 5'd1, 7'(op)};
  endfunction

  initial begin
    instr = 32'h0; eq = 0; lt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 add and sub
    drive(enc(0, 0, 'h33), 0, 0);
    drive(enc('h20, 0, 'h33), 0, 0);
    // R2 every funct3 and sra
    for (int f = 1; f < 8; f++) drive(enc(0, f, 'h33), 0, 0);
    drive(enc('h20, 5, 'h33), 0, 0);
    // R3 illegal funct7
    drive(enc('h20, 4, 'h33), 0, 0);
    drive(enc('h01, 0, 'h33), 0, 0);
    // R4 addi with bit30 set must still add; xori with bit30 set
    drive(enc('h20, 0, 'h13), 0, 0);
    drive(enc('h7f, 4, 'h13), 0, 0);
    // R5 shifts
    drive(enc(0, 5, 'h13), 0, 0);
    drive(enc('h20, 5, 'h13), 0, 0);
    drive(enc('h20, 1, 'h13), 0, 0);
    drive(enc('h10, 5, 'h13), 0, 0);
    // R6 lw, R10 lh
    drive(enc(0, 2, 'h03), 0, 0);
    drive(enc(0, 1, 'h03), 0, 0);
    // R7 sw, R10 sb
    drive(enc(0, 2, 'h23), 0, 0);
    drive(enc(0, 0, 'h23), 0, 0);
    // R8 R9 every branch funct3 under every flag pair
    for (int f = 0; f < 8; f++)
      for (int fl = 0; fl < 4; fl++) drive(enc(0, f, 'h63), fl[1], fl[0]);
    // R10 other opcodes
    drive(enc(0, 0, 'h6f), 1, 1);
    drive(enc(0, 0, 'h37), 1, 1);
    // random mix of all classes
    for (int n = 0; n < 3000; n++) begin
      int sel, f7;
      logic [31:0] w;
      sel = $urandom_range(0, 6);
      w = $urandom;
      case (sel)
        0: w[6:0] = 7'h33; 1: w[6:0] = 7'h13; 2: w[6:0] = 7'h03;
        3: w[6:0] = 7'h23; 4: w[6:0] = 7'h63; default: ;
      endcase
      f7 = $urandom_range(0, 3);
      if (f7 == 0) w[31:25] = 7'h00; else if (f7 == 1) w[31:25] = 7'h20;
      drive(w, 1'($urandom), 1'($urandom));
    end
    @(posedge clk); #1;
    @(negedge clk); #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule